// File: doc/BRIEF.md
# Dual-bus Manchester word decoder

This block turns the digitized levels of one serial avionics bus into received 16-bit words. It watches a pair of comparator outputs, one per line polarity, and with a 12 MHz clock (twelve clocks per 1.0 us bit) it locates the three-bit-time sync, tells a command sync (positive half first) from a data sync (negative half first), then decodes sixteen Manchester data bits and one parity bit. A chip with two buses places two instances side by side, one per bus, and feeds their results into its own receive registers.

Each word ends in exactly one of two outcomes. A word with good encoding, a full bit count and odd parity raises a one-clock valid strobe and loads the word and its sync type. Any fault raises a one-clock error strobe instead and leaves the held word alone. A one-clock start strobe marks each detected sync, so that the host side can drop a stale received flag. An idle flag reports a quiet bus, and a low receiver enable makes the block blind to the bus.

Top module: `mdec_rx`

## Requirements
- R1: After reset rx_valid, rx_err and rx_sow are 0, rx_word is 0, rx_cmd is 0 and rx_idle is 1.
- R2: A sync is a run of 15 to 27 clocks at one definite level followed by the opposite level; rx_sow pulses for one clock, visible after the second rising edge following the clock in which the first sample of the opposite half is presented. A level is definite when exactly one of line_p (high level) and line_n (low level) is set.
- R3: Each data bit lasts 12 clocks; logic one is high for 6 clocks then low for 6. The first bit received lands in rx_word[15]. On a good word rx_valid pulses once, two edges after the parity bit's 10th sample (index 9) is presented, with rx_word and rx_cmd (1 for command sync, 0 for data sync) loaded in the same cycle; rx_word does not change at any other time.
- R4: The 16 data bits plus the parity bit must hold an odd number of ones; otherwise rx_err pulses at the time R3 gives for rx_valid, no valid pulse follows and rx_word and rx_cmd keep their values.
- R5: A data or parity bit whose samples at indices 3 and 9 are not opposite definite levels raises rx_err two edges after its index-9 sample, and no valid pulse is raised for that word.
- R6: A word that goes quiet (no definite level) before its parity bit ends is rejected by rx_err at the first missing bit, by the R5 timing.
- R7: If the sample at index 9 of the second sync half is not the expected opposite level, rx_err pulses two edges after it and the word is dropped.
- R8: rx_idle is high exactly while the sampled input pair has not changed for more than 24 clocks.
- R9: While rx_en is low the inputs are treated as quiet: no sync, word or error is reported and rx_idle stays high.
- R10: Words sent back to back are each decoded, including when the parity half and the next sync's first half share a level and form one 24-clock run.
- R11: rx_valid and rx_err never rise together and each lasts a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable |
| line_p | input | 1 | Comparator output, bus above positive threshold |
| line_n | input | 1 | Comparator output, bus below negative threshold |
| rx_word | output | 16 | Last valid word, first bit in bit 15 |
| rx_cmd | output | 1 | Sync type of last valid word, 1 = command |
| rx_valid | output | 1 | One-clock strobe for a valid word |
| rx_err | output | 1 | One-clock strobe for a rejected word |
| rx_sow | output | 1 | One-clock strobe on sync detection |
| rx_idle | output | 1 | Bus quiet for more than 24 clocks |

## Verification
Every result is tied to the clock in which its deciding sample is presented: start 20 clocks after the first sync sample, error 47 + 12·j clocks after it for a fault in bit j, and valid 239 clocks after it, with the idle flag following the input run length by two clocks. The bench builds each stimulus clock by clock, records from these offsets the cycle in which each strobe must appear, and compares all strobes and the idle flag on every clock, so a strobe one cycle early or late, or an extra one, is reported. Word and sync type are compared at each valid or error event, which also shows that a rejected word leaves the held value untouched.

// File: rtl/mdec_rx.sv
module mdec_rx #(
  parameter int CLK_PER_BIT = 12,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              line_p,
  input  logic              line_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_cmd,
  output logic              rx_valid,
  output logic              rx_err,
  output logic              rx_sow,
  output logic              rx_idle
);
  localparam int Q1        = CLK_PER_BIT / 4;
  localparam int Q3        = (3 * CLK_PER_BIT) / 4;
  localparam int SYNC_HALF = (3 * CLK_PER_BIT) / 2;
  localparam int SYNC_MIN  = SYNC_HALF - Q1;
  localparam int SYNC_MAX  = SYNC_HALF + Q3;
  localparam int IDLE_LIM  = 2 * CLK_PER_BIT;
  localparam int RUN_W     = $clog2(SYNC_MAX + IDLE_LIM + 1);
  localparam int TW        = $clog2(SYNC_HALF);
  localparam int BW        = $clog2(WORD_W + 1);

  localparam logic [RUN_W-1:0] R_MAX  = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] R_MIN  = RUN_W'(SYNC_MIN);
  localparam logic [RUN_W-1:0] R_TOP  = RUN_W'(SYNC_MAX);
  localparam logic [RUN_W-1:0] R_IDLE = RUN_W'(IDLE_LIM);
  localparam logic [TW-1:0]    T_Q1   = TW'(Q1);
  localparam logic [TW-1:0]    T_Q3   = TW'(Q3);
  localparam logic [TW-1:0]    T_LAST = TW'(CLK_PER_BIT - 1);
  localparam logic [TW-1:0]    T_SEND = TW'(SYNC_HALF - 1);
  localparam logic [BW-1:0]    B_LAST = BW'(WORD_W);
  localparam logic [1:0]       L_HI   = 2'b10;
  localparam logic [1:0]       L_LO   = 2'b01;

  typedef enum logic [1:0] {HUNT, SYNC2, DATA} st_t;

  st_t               st;
  logic [1:0]        s_q, s_d, first;
  logic [RUN_W-1:0]  run;
  logic [TW-1:0]     tick;
  logic [BW-1:0]     bitn;
  logic [WORD_W-1:0] sh;
  logic              cmd_q, par;
  logic              sync_edge, s2_ok, good, bitv;

  assign sync_edge = ((s_q == L_HI && s_d == L_LO) || (s_q == L_LO && s_d == L_HI)) &&
                     run >= R_MIN && run <= R_TOP;
  assign s2_ok     = s_q == (cmd_q ? L_LO : L_HI);
  assign good      = (first == L_HI && s_q == L_LO) || (first == L_LO && s_q == L_HI);
  assign bitv      = first == L_HI;
  assign rx_idle   = run > R_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= HUNT;
      s_q      <= 2'b00;
      s_d      <= 2'b00;
      first    <= 2'b00;
      run      <= R_MAX;
      tick     <= '0;
      bitn     <= '0;
      sh       <= '0;
      cmd_q    <= 1'b0;
      par      <= 1'b0;
      rx_word  <= '0;
      rx_cmd   <= 1'b0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      rx_sow   <= 1'b0;
    end else begin
      s_q      <= rx_en ? {line_p, line_n} : 2'b00;
      s_d      <= s_q;
      run      <= (s_q != s_d) ? RUN_W'(1) : ((run == R_MAX) ? run : run + 1'b1);
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      rx_sow   <= 1'b0;
      if (!rx_en) begin
        st <= HUNT;
      end else begin
        case (st)
          HUNT: if (sync_edge) begin
            st     <= SYNC2;
            tick   <= TW'(1);
            cmd_q  <= s_d == L_HI;
            par    <= 1'b0;
            bitn   <= '0;
            rx_sow <= 1'b1;
          end
          SYNC2: begin
            if (tick == T_Q3 && !s2_ok) begin
              rx_err <= 1'b1;
              st     <= HUNT;
            end else if (tick == T_SEND) begin
              st   <= DATA;
              tick <= '0;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          DATA: begin
            if (tick == T_Q1) first <= s_q;
            if (tick == T_Q3) begin
              if (!good) begin
                rx_err <= 1'b1;
                st     <= HUNT;
              end else if (bitn == B_LAST) begin
                if (par ^ bitv) begin
                  rx_valid <= 1'b1;
                  rx_word  <= sh;
                  rx_cmd   <= cmd_q;
                end else begin
                  rx_err <= 1'b1;
                end
                st <= HUNT;
              end else begin
                sh  <= {sh[WORD_W-2:0], bitv};
                par <= par ^ bitv;
              end
            end
            if (tick == T_LAST) begin
              tick <= '0;
              bitn <= bitn + 1'b1;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          default: st <= HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdec_rx_chk.sv
module mdec_rx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              rx_err,
  input logic              rx_sow,
  input logic              rx_idle
);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_err));
  a_r11_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r11_err_single: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !rx_err);
  a_r3_word_held: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_word));
  a_r9_blind: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_valid && !rx_err && !rx_sow));
  a_r8_busy_on_word: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !rx_idle);
  a_r2_sow_gap: assert property (@(posedge clk) disable iff (rst)
    rx_sow |=> (!rx_valid && !rx_err));
endmodule

bind mdec_rx mdec_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rx_word(rx_word),
  .rx_valid(rx_valid), .rx_err(rx_err), .rx_sow(rx_sow), .rx_idle(rx_idle)
);

// File: tb/mdec_rx_tb_top.sv
module mdec_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] HI = 2'b10, LO = 2'b01, NUL = 2'b00;

  logic clk = 1'b0, rst = 1'b1, rx_en = 1'b0, line_p = 1'b0, line_n = 1'b0;
  logic [15:0] rx_word;
  logic rx_cmd, rx_valid, rx_err, rx_sow, rx_idle;

  mdec_rx dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .line_p(line_p), .line_n(line_n),
    .rx_word(rx_word), .rx_cmd(rx_cmd), .rx_valid(rx_valid), .rx_err(rx_err),
    .rx_sow(rx_sow), .rx_idle(rx_idle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  stim[$];
  bit          enq[$];
  logic [1:0]  hist[int];
  bit          ev_sow[int], ev_val[int], ev_err[int];
  string       ev_tag[int];
  logic [15:0] ev_word[int];
  bit          ev_cmd[int];
  bit          build_en = 1'b1;
  logic [15:0] m_word = '0;
  bit          m_cmd = 1'b0;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] c, int n);
    repeat (n) begin
      stim.push_back(c);
      enq.push_back(build_en);
    end
  endtask

  task automatic mark_err(int k, string tag);
    if (!build_en) return;
    ev_err[k] = 1'b1; ev_tag[k] = tag; ev_word[k] = m_word; ev_cmd[k] = m_cmd;
  endtask

  task automatic add_word(bit cmd, logic [15:0] d, int bad_bit, bit flip_par,
                          int trunc_at, bit bad_s2, string tag);
    int s;
    s = stim.size();
    push(cmd ? HI : LO, 18);
    if (build_en) begin ev_sow[s+20] = 1'b1; ev_tag[s+20] = tag; end
    if (bad_s2) begin
      push(cmd ? LO : HI, 4);
      push(cmd ? HI : LO, 14);
      mark_err(s + 29, tag);
      return;
    end
    push(cmd ? LO : HI, 18);
    for (int j = 0; j < 17; j++) begin
      bit b;
      b = (j < 16) ? d[15-j] : (~(^d) ^ flip_par);
      if (j == trunc_at) begin mark_err(s + 47 + 12*j, tag); return; end
      if (j == bad_bit) begin push(b ? HI : LO, 12); mark_err(s + 47 + 12*j, tag); return; end
      push(b ? HI : LO, 6);
      push(b ? LO : HI, 6);
    end
    if (flip_par) mark_err(s + 239, tag);
    else if (build_en) begin
      m_word = d; m_cmd = cmd;
      ev_val[s+239] = 1'b1; ev_tag[s+239] = tag; ev_word[s+239] = d; ev_cmd[s+239] = cmd;
    end
  endtask

  function automatic int runlen(int idx);
    int n;
    logic [1:0] ref_v, v;
    if (idx < 0) return 100;
    ref_v = hist[idx];
    n = 0;
    for (int j = idx; n < 100; j--) begin
      v = (j < 0) ? NUL : hist[j];
      if (v != ref_v) break;
      n++;
    end
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int total;
    push(NUL, 40);
    add_word(1'b1, 16'hA5C3, -1, 1'b0, -1, 1'b0, "R3");
    push(NUL, 30);
    add_word(1'b0, 16'h1234, -1, 1'b0, -1, 1'b0, "R2");
    push(NUL, 30);
    add_word(1'b1, 16'hFFFF, -1, 1'b0, -1, 1'b0, "R3");
    push(NUL, 30);
    add_word(1'b0, 16'h0F0F, -1, 1'b1, -1, 1'b0, "R4");
    push(NUL, 30);
    add_word(1'b1, 16'h0F0F, 5, 1'b0, -1, 1'b0, "R5");
    push(NUL, 30);
    add_word(1'b0, 16'h3C3C, -1, 1'b0, 10, 1'b0, "R6");
    push(NUL, 30);
    add_word(1'b1, 16'h5A5A, -1, 1'b0, -1, 1'b1, "R7");
    push(NUL, 30);
    add_word(1'b1, 16'h0001, -1, 1'b0, -1, 1'b0, "R10");
    add_word(1'b1, 16'h8000, -1, 1'b0, -1, 1'b0, "R10");
    add_word(1'b0, 16'h0000, -1, 1'b0, -1, 1'b0, "R10");
    add_word(1'b0, 16'h7777, -1, 1'b0, -1, 1'b0, "R10");
    push(NUL, 30);
    build_en = 1'b0;
    push(NUL, 5);
    add_word(1'b1, 16'h5555, -1, 1'b0, -1, 1'b0, "R9");
    push(NUL, 10);
    build_en = 1'b1;
    push(NUL, 40);
    total = stim.size();

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < total + 4; k++) begin
      logic [1:0] c;
      bit e, xv, xe, xs, xi;
      string tg;
      if (k == 0) begin
        chk(rx_word == 16'h0 && rx_cmd == 1'b0, "R1", "word/cmd after reset", rx_word, 0);
        chk(rx_idle == 1'b1, "R1", "idle after reset", rx_idle, 1);
      end
      xv = ev_val.exists(k);
      xe = ev_err.exists(k);
      xs = ev_sow.exists(k);
      xi = runlen(k - 2) > 24;
      tg = ev_tag.exists(k) ? ev_tag[k] : "";
      chk(rx_valid == xv, (tg != "") ? tg : "R3", $sformatf("valid @%0d", k), rx_valid, xv);
      chk(rx_err == xe, (tg != "") ? tg : "R5", $sformatf("err @%0d", k), rx_err, xe);
      chk(rx_sow == xs, (tg != "") ? tg : "R2", $sformatf("sow @%0d", k), rx_sow, xs);
      chk(rx_idle == xi, "R8", $sformatf("idle @%0d", k), rx_idle, xi);
      chk(!(rx_valid && rx_err), "R11", $sformatf("both strobes @%0d", k), {rx_valid, rx_err}, 0);
      if (xv || xe) begin
        chk(rx_word == ev_word[k], tg, $sformatf("word @%0d", k), rx_word, ev_word[k]);
        chk(rx_cmd == ev_cmd[k], tg, $sformatf("sync type @%0d", k), rx_cmd, ev_cmd[k]);
      end
      c = (k < total) ? stim[k] : NUL;
      e = (k < total) ? enq[k] : 1'b1;
      line_p = c[1];
      line_n = c[0];
      rx_en  = e;
      hist[k] = e ? c : NUL;
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule